// File: doc/BRIEF.md
# Bitmap Trigger Handshake Sequencer

This engine accepts an 8-bit request bitmap from a client. For every bit that is set, it runs a trigger-and-acknowledge exchange with a remote sequencer. It does this through a byte-wide register master port that reaches three registers: a trigger control register, a request scratch register and a status scratch register. Bits are served one at a time, lowest first. Each bit goes through four steps in order: clear its status bit, set its request bit, fire the trigger, then poll the status register. The poll is bounded in time. When the bitmap is finished, the client gets one completion pulse with a result code: success, invalid argument, refused (NACK), timeout or bus error.

A second client command performs only the trigger-fire step, with no handshake. Any request that arrives while the engine is working is dropped. The poll spacing and the poll limit are counted in clock cycles and set by parameters.

Every masked write is performed as a read followed by a write of `(old & ~mask) | (value & mask)`. All register addresses are a parameterised base plus a fixed offset.

Top module: `trig_handshake_seq`

## Requirements
- R1: Every access targets one of three addresses: trigger control at BASE+0x42 (fire bit is bit 7), request scratch at BASE+0x50, or status scratch at BASE+0x51.
- R2: A request with an all-zero bitmap completes in the cycle after it is accepted, with result code 1 (invalid), and issues no bus access.
- R3: Before any bit is served, the status register is read. If it reads 0xFF, a full write of 0x00 to it follows.
- R4: Requested bits are served in ascending order and unrequested bits are skipped. Each served bit runs these steps in order: a masked clear of its status bit, a masked set of its request bit, a masked set of trigger bit 7, then status reads.
- R5: A masked write is a read of the register followed by a write of `(read & ~mask) | (value & mask)` to the same address.
- R6: A status read that is not 0xFF and has the served bit set acknowledges that bit. The engine then clears the bit in the request register and then in the status register, and moves to the next requested bit.
- R7: A status read of exactly 0xFF is a NACK, even if the served bit is set. The engine writes 0x00 to the status register, serves no further bits, and ends with result code 2.
- R8: After MAX_POLLS status reads without an acknowledge or a NACK, the request ends with result code 3. Consecutive status reads for one bit are more than POLL_GAP clock cycles apart.
- R9: Every exit after the initial status check ends with one masked write that clears all bits of the original bitmap in the request register. Success gives result code 0.
- R10: An error response on any access stops the sequence with result code 4. If the error happens during the initial status check, the request-register clean-up is skipped; otherwise it is still performed.
- R11: The single-trigger command performs exactly one masked write that sets trigger bit 7, and ends with code 0, or with code 4 on a bus error.
- R12: Commands are accepted only while the engine is idle. If a bitmap request and a single-trigger command arrive in the same cycle, the bitmap request wins. Commands that arrive while busy have no effect, and no bus access happens while idle.
- R13: A bus request holds its address, direction and write data unchanged until the cycle in which ready is high.
- R14: Completion is a single-cycle pulse on done_valid, with the result on done_status, and it is given once per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Start a bitmap request (taken when idle) |
| req_bitmap | input | 8 | Bits to serve |
| single_req | input | 1 | Start a trigger-only command |
| busy | output | 1 | A command is in progress |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | 0 ok, 1 invalid, 2 NACK, 3 timeout, 4 bus error |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Error response, valid with bus_ready |

## Verification
The bench builds the engine with POLL_GAP = 3, MAX_POLLS = 4 and BASE = 0x1200. With these values, the timeout path, the full set of poll attempts and the spacing between polls can all be reached within a few dozen cycles. Because the base is non-zero, any offset that is not added to it shows up as a wrong address. The responder model can answer on a chosen poll, return NACK for a chosen bit, inject an error on a chosen access number, and insert wait states. These settings steer the engine through every exit path and make the bench check that requests are held stable.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    localparam int DATA_W   = 8;
    localparam int FIRE_BIT = 7;

    localparam logic [7:0] OFS_TRIG = 8'h42;
    localparam logic [7:0] OFS_REQ  = 8'h50;
    localparam logic [7:0] OFS_STAT = 8'h51;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_INVAL   = 3'd1,
        RES_NACK    = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_BUSERR  = 3'd4
    } result_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_PRE_RD, S_PRE_CLR, S_PICK, S_CLR_ST, S_SET_RQ, S_FIRE,
        S_POLL, S_WAIT, S_NACK_CLR, S_ACK_RQ, S_ACK_ST, S_CLEANUP,
        S_SINGLE, S_FINISH
    } seq_state_e;

endpackage

// File: rtl/trig_seq_bus.sv
module trig_seq_bus
    import trig_seq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_mask,
    input  logic [DATA_W-1:0] cmd_val,
    output logic              acc_done,
    output logic              acc_err,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err
);

    typedef enum logic [1:0] { PH_IDLE, PH_RD, PH_WR } phase_e;

    typedef struct packed {
        phase_e            ph;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } acc_regs_t;

    acc_regs_t q, d;

    always_comb begin
        d        = q;
        acc_done = 1'b0;
        acc_err  = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    d.op   = cmd_op;
                    d.addr = cmd_addr;
                    d.mask = cmd_mask;
                    d.data = cmd_val;
                    d.ph   = (cmd_op == OP_WRITE) ? PH_WR : PH_RD;
                end
            end
            PH_RD: begin
                if (bus_ready) begin
                    if (bus_err || q.op == OP_READ) begin
                        acc_done = 1'b1;
                        acc_err  = bus_err;
                        d.ph     = PH_IDLE;
                    end else begin
                        d.data = (bus_rdata & ~q.mask) | (q.data & q.mask);
                        d.ph   = PH_WR;
                    end
                end
            end
            PH_WR: begin
                if (bus_ready) begin
                    acc_done = 1'b1;
                    acc_err  = bus_err;
                    d.ph     = PH_IDLE;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, op: OP_READ, addr: '0, mask: '0, data: '0};
        end else begin
            q <= d;
        end
    end

    assign acc_rdata = bus_rdata;
    assign bus_req   = (q.ph != PH_IDLE);
    assign bus_we    = (q.ph == PH_WR);
    assign bus_addr  = q.addr;
    assign bus_wdata = q.data;

endmodule

// File: rtl/trig_seq_lowest.sv
module trig_seq_lowest #(
    parameter int W = 8,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    logic [W:0]   below;
    logic [W-1:0] first;

    assign below[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_scan
        assign first[i]   = vec[i] & ~below[i];
        assign below[i+1] = below[i] | vec[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign any = below[W];

endmodule

// File: rtl/trig_seq_pacer.sv
module trig_seq_pacer #(
    parameter int POLL_GAP  = 50000,
    parameter int MAX_POLLS = 2000,
    localparam int GW = $clog2(POLL_GAP + 1),
    localparam int AW = $clog2(MAX_POLLS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic fail_poll,
    output logic gap_over,
    output logic last_try
);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [AW-1:0] tries;
    } pace_regs_t;

    pace_regs_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.tries = '0;
        end
        if (fail_poll) begin
            d.tries = q.tries + 1'b1;
            d.gap   = GW'(POLL_GAP);
        end else if (q.gap != '0) begin
            d.gap = q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{gap: '0, tries: '0};
        end else begin
            q <= d;
        end
    end

    assign gap_over = (q.gap == '0);
    assign last_try = (q.tries == AW'(MAX_POLLS - 1));

endmodule

// File: rtl/trig_handshake_seq.sv
module trig_handshake_seq
    import trig_seq_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE    = 16'h0A00,
    parameter int              POLL_GAP  = 50000,
    parameter int              MAX_POLLS = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [7:0]        req_bitmap,
    input  logic              single_req,
    output logic              busy,
    output logic              done_valid,
    output logic [2:0]        done_status,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    input  logic              bus_err
);

    localparam int BW = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] FIRE_MASK = DATA_W'(1) << FIRE_BIT;
    localparam logic [DATA_W-1:0] ALL_ONES  = '1;

    localparam logic [ADDR_W-1:0] A_TRIG = BASE + ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_REQ  = BASE + ADDR_W'(OFS_REQ);
    localparam logic [ADDR_W-1:0] A_STAT = BASE + ADDR_W'(OFS_STAT);

    typedef struct packed {
        seq_state_e        st;
        result_e           res;
        logic [DATA_W-1:0] map;
        logic [DATA_W-1:0] rem;
        logic [BW-1:0]     bit_no;
    } seq_regs_t;

    seq_regs_t q, d;

    logic              cmd_valid;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_mask;
    logic [DATA_W-1:0] cmd_val;
    logic              acc_done;
    logic              acc_err;
    logic [DATA_W-1:0] acc_rdata;
    logic [BW-1:0]     next_bit;
    logic              any_left;
    logic              restart;
    logic              fail_poll;
    logic              gap_over;
    logic              last_try;
    logic [DATA_W-1:0] cur_mask;

    trig_seq_bus #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_mask  (cmd_mask),
        .cmd_val   (cmd_val),
        .acc_done  (acc_done),
        .acc_err   (acc_err),
        .acc_rdata (acc_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_err   (bus_err)
    );

    trig_seq_lowest #(.W(DATA_W)) u_pick (
        .vec (q.rem),
        .idx (next_bit),
        .any (any_left)
    );

    trig_seq_pacer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_pace (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .fail_poll (fail_poll),
        .gap_over  (gap_over),
        .last_try  (last_try)
    );

    assign cur_mask = DATA_W'(1) << q.bit_no;

    // Command presented to the access unit in each bus-facing state.
    always_comb begin
        cmd_valid = 1'b1;
        cmd_op    = OP_RMW;
        cmd_addr  = A_STAT;
        cmd_mask  = cur_mask;
        cmd_val   = '0;
        case (q.st)
            S_PRE_RD, S_POLL: cmd_op = OP_READ;
            S_PRE_CLR, S_NACK_CLR: begin
                cmd_op   = OP_WRITE;
                cmd_mask = ALL_ONES;
            end
            S_CLR_ST, S_ACK_ST: ;
            S_SET_RQ: begin
                cmd_addr = A_REQ;
                cmd_val  = cur_mask;
            end
            S_ACK_RQ: cmd_addr = A_REQ;
            S_FIRE, S_SINGLE: begin
                cmd_addr = A_TRIG;
                cmd_mask = FIRE_MASK;
                cmd_val  = FIRE_MASK;
            end
            S_CLEANUP: begin
                cmd_addr = A_REQ;
                cmd_mask = q.map;
            end
            default: cmd_valid = 1'b0;
        endcase
    end

    // Sequencing of the handshake.
    always_comb begin
        d         = q;
        restart   = 1'b0;
        fail_poll = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start_req) begin
                    d.map = req_bitmap;
                    d.rem = req_bitmap;
                    if (req_bitmap == '0) begin
                        d.res = RES_INVAL;
                        d.st  = S_FINISH;
                    end else begin
                        d.res = RES_OK;
                        d.st  = S_PRE_RD;
                    end
                end else if (single_req) begin
                    d.res = RES_OK;
                    d.st  = S_SINGLE;
                end
            end
            S_PRE_RD: begin
                if (acc_done) begin
                    if (acc_err) begin
                        d.res = RES_BUSERR;
                        d.st  = S_FINISH;
                    end else if (acc_rdata == ALL_ONES) begin
                        d.st = S_PRE_CLR;
                    end else begin
                        d.st = S_PICK;
                    end
                end
            end
            S_PRE_CLR: begin
                if (acc_done) begin
                    if (acc_err) begin
                        d.res = RES_BUSERR;
                        d.st  = S_FINISH;
                    end else begin
                        d.st = S_PICK;
                    end
                end
            end
            S_PICK: begin
                if (any_left) begin
                    d.bit_no = next_bit;
                    d.st     = S_CLR_ST;
                end else begin
                    d.st = S_CLEANUP;
                end
            end
            S_CLR_ST, S_SET_RQ, S_FIRE, S_ACK_RQ: begin
                if (acc_done) begin
                    if (acc_err) begin
                        d.res = RES_BUSERR;
                        d.st  = S_CLEANUP;
                    end else begin
                        case (q.st)
                            S_CLR_ST: d.st = S_SET_RQ;
                            S_SET_RQ: d.st = S_FIRE;
                            S_FIRE:   d.st = S_POLL;
                            default:  d.st = S_ACK_ST;
                        endcase
                    end
                    restart = (q.st == S_FIRE);
                end
            end
            S_POLL: begin
                if (acc_done) begin
                    if (acc_err) begin
                        d.res = RES_BUSERR;
                        d.st  = S_CLEANUP;
                    end else if (acc_rdata == ALL_ONES) begin
                        d.st = S_NACK_CLR;
                    end else if ((acc_rdata & cur_mask) != '0) begin
                        d.st = S_ACK_RQ;
                    end else if (last_try) begin
                        d.res = RES_TIMEOUT;
                        d.st  = S_CLEANUP;
                    end else begin
                        fail_poll = 1'b1;
                        d.st      = S_WAIT;
                    end
                end
            end
            S_WAIT: begin
                if (gap_over) d.st = S_POLL;
            end
            S_NACK_CLR: begin
                if (acc_done) begin
                    d.res = acc_err ? RES_BUSERR : RES_NACK;
                    d.st  = S_CLEANUP;
                end
            end
            S_ACK_ST: begin
                if (acc_done) begin
                    if (acc_err) begin
                        d.res = RES_BUSERR;
                        d.st  = S_CLEANUP;
                    end else begin
                        d.rem = q.rem & ~cur_mask;
                        d.st  = S_PICK;
                    end
                end
            end
            S_CLEANUP: begin
                if (acc_done) begin
                    if (acc_err && q.res == RES_OK) d.res = RES_BUSERR;
                    d.st = S_FINISH;
                end
            end
            S_SINGLE: begin
                if (acc_done) begin
                    d.res = acc_err ? RES_BUSERR : RES_OK;
                    d.st  = S_FINISH;
                end
            end
            S_FINISH: d.st = S_IDLE;
            default:  d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, res: RES_OK, map: '0, rem: '0, bit_no: '0};
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != S_IDLE);
    assign done_valid  = (q.st == S_FINISH);
    assign done_status = q.res;

endmodule

// File: rtl/trig_seq_checker.sv
module trig_seq_checker #(
    parameter int              ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h0A00
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_req,
    input logic [7:0]        req_bitmap,
    input logic              busy,
    input logic              done_valid,
    input logic [2:0]        done_status,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ready
);

    localparam logic [ADDR_W-1:0] CA_TRIG = BASE + ADDR_W'(8'h42);
    localparam logic [ADDR_W-1:0] CA_REQ  = BASE + ADDR_W'(8'h50);
    localparam logic [ADDR_W-1:0] CA_STAT = BASE + ADDR_W'(8'h51);

    assert_addr_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr == CA_TRIG || bus_addr == CA_REQ || bus_addr == CA_STAT));

    assert_zero_inval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_req && req_bitmap == 8'h00) |=> (done_valid && done_status == 3'd1));

    assert_fire_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == CA_TRIG) |-> bus_wdata[7]);

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (!done_valid && !busy));

endmodule

bind trig_handshake_seq trig_seq_checker #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .req_bitmap  (req_bitmap),
    .busy        (busy),
    .done_valid  (done_valid),
    .done_status (done_status),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ready   (bus_ready)
);

// File: tb/trig_handshake_seq_test.sv
module trig_handshake_seq_test;

    localparam int          GAP  = 3;
    localparam int          MAXP = 4;
    localparam logic [15:0] BASE = 16'h1200;
    localparam logic [15:0] A_TR = BASE + 16'h42;
    localparam logic [15:0] A_RQ = BASE + 16'h50;
    localparam logic [15:0] A_ST = BASE + 16'h51;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_req = 1'b0;
    logic [7:0]  req_bitmap = 8'h00;
    logic        single_req = 1'b0;
    logic        busy, done_valid;
    logic [2:0]  done_status;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;
    logic        bus_ready = 1'b0;
    logic        bus_err = 1'b0;

    always #2 clk = ~clk;

    trig_handshake_seq #(.ADDR_W(16), .BASE(BASE), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .req_bitmap(req_bitmap),
        .single_req(single_req), .busy(busy), .done_valid(done_valid),
        .done_status(done_status), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .bus_err(bus_err)
    );

    typedef struct {
        bit          we;
        int          kind;   // 0 read, 1 full write, 2 masked-write data phase
        logic [15:0] addr;
        logic [7:0]  m;
        logic [7:0]  v;
        bit          poll;
    } exp_t;

    exp_t expq[$];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // responder configuration and state
    int          ack_after;
    logic [7:0]  nack_mask;
    int          err_at;
    bit          slow;
    logic [7:0]  trig_r, s1_r, s2_r, last_rd;
    bit          armed, waited, prev_poll_ok;
    int          pcount, txn_idx, gen_idx, prev_poll_cyc, done_cnt, got_status;
    logic [15:0] hold_addr;
    logic [7:0]  hold_wdata;
    bit          hold_we;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp_v);
        end
    endtask

    task automatic g_txn(input bit we, input int kind, input logic [15:0] a,
                         input logic [7:0] m, input logic [7:0] v, input bit poll,
                         output bit e);
        exp_t x;
        x.we = we; x.kind = kind; x.addr = a; x.m = m; x.v = v; x.poll = poll;
        expq.push_back(x);
        e = (gen_idx == err_at);
        gen_idx++;
    endtask

    task automatic g_rmw(input logic [15:0] a, input logic [7:0] m,
                         input logic [7:0] v, output bit e);
        g_txn(1'b0, 0, a, m, v, 1'b0, e);
        if (!e) g_txn(1'b1, 2, a, m, v, 1'b0, e);
    endtask

    // Expected access list and result, derived from the requirements.
    task automatic build_expect(input logic [7:0] bm, input logic [7:0] pre, output int st);
        bit e, stop, acked;
        logic [7:0] b;
        expq.delete();
        gen_idx = 0;
        st = 0;
        stop = 0;
        if (bm == 8'h00) begin st = 1; return; end
        g_txn(1'b0, 0, A_ST, 8'h00, 8'h00, 1'b0, e);
        if (e) begin st = 4; return; end
        if (pre == 8'hFF) begin
            g_txn(1'b1, 1, A_ST, 8'hFF, 8'h00, 1'b0, e);
            if (e) begin st = 4; return; end
        end
        for (int i = 0; i < 8; i++) begin
            if (bm[i] && !stop) begin
                b = 8'(1 << i);
                acked = 0;
                g_rmw(A_ST, b, 8'h00, e);
                if (e) begin st = 4; stop = 1; end
                if (!stop) begin g_rmw(A_RQ, b, b, e); if (e) begin st = 4; stop = 1; end end
                if (!stop) begin g_rmw(A_TR, 8'h80, 8'h80, e); if (e) begin st = 4; stop = 1; end end
                for (int k = 1; k <= MAXP; k++) begin
                    if (!stop && !acked) begin
                        g_txn(1'b0, 0, A_ST, 8'h00, 8'h00, 1'b1, e);
                        if (e) begin st = 4; stop = 1; end
                        else if (ack_after == k) begin
                            if (nack_mask[i]) begin
                                g_txn(1'b1, 1, A_ST, 8'hFF, 8'h00, 1'b0, e);
                                st = e ? 4 : 2;
                                stop = 1;
                            end else acked = 1;
                        end else if (k == MAXP) begin st = 3; stop = 1; end
                    end
                end
                if (acked) begin
                    g_rmw(A_RQ, b, 8'h00, e);
                    if (e) begin st = 4; stop = 1; end
                    if (!stop) begin g_rmw(A_ST, b, 8'h00, e); if (e) begin st = 4; stop = 1; end end
                end
            end
        end
        g_rmw(A_RQ, bm, 8'h00, e);
        if (e && st == 0) st = 4;
    endtask

    task automatic serve();
        exp_t x;
        bit hit;
        logic [7:0] rv, expw;
        hit = (txn_idx == err_at);
        txn_idx++;
        if (expq.size() == 0) begin
            chk(1'b0, "R12", "unexpected bus access at address", int'(bus_addr), 0);
        end else begin
            x = expq.pop_front();
            chk(bus_we == x.we, "R4", "access direction", int'(bus_we), int'(x.we));
            chk(bus_addr == x.addr, "R1", "access address", int'(bus_addr), int'(x.addr));
            if (bus_we && x.kind == 1)
                chk(bus_wdata == x.v, "R3", "full write data", int'(bus_wdata), int'(x.v));
            if (bus_we && x.kind == 2) begin
                expw = (last_rd & ~x.m) | (x.v & x.m);
                chk(bus_wdata == expw, "R5", "masked write data", int'(bus_wdata), int'(expw));
            end
            if (x.poll) begin
                if (prev_poll_ok)
                    chk(cyc - prev_poll_cyc > GAP, "R8", "poll spacing", cyc - prev_poll_cyc, GAP + 1);
                prev_poll_ok = 1;
                prev_poll_cyc = cyc;
            end else prev_poll_ok = 0;
        end
        bus_err = hit;
        bus_rdata = 8'h00;
        if (!hit) begin
            if (!bus_we) begin
                if (bus_addr == A_ST) begin
                    if (armed) begin
                        pcount++;
                        if (pcount == ack_after) begin
                            armed = 0;
                            if ((s1_r & nack_mask) != 8'h00) s2_r = 8'hFF;
                            else s2_r = s2_r | s1_r;
                        end
                    end
                    rv = s2_r;
                end else if (bus_addr == A_RQ) rv = s1_r;
                else rv = trig_r;
                bus_rdata = rv;
                last_rd = rv;
            end else begin
                if (bus_addr == A_TR) begin
                    trig_r = bus_wdata & 8'h7F;
                    if (bus_wdata[7]) begin armed = 1; pcount = 0; end
                end else if (bus_addr == A_RQ) s1_r = bus_wdata;
                else s2_r = bus_wdata;
            end
        end
    endtask

    // Responder and monitor, acting away from the active edge.
    always @(negedge clk) begin
        bus_ready = 1'b0;
        bus_err = 1'b0;
        if (rst_n) begin
            if (bus_req) begin
                if (slow && !waited) begin
                    waited = 1;
                    hold_addr = bus_addr; hold_we = bus_we; hold_wdata = bus_wdata;
                end else begin
                    if (waited)
                        chk(hold_addr == bus_addr && hold_we == bus_we && hold_wdata == bus_wdata,
                            "R13", "request changed while waiting", int'(bus_addr), int'(hold_addr));
                    waited = 0;
                    serve();
                    bus_ready = 1'b1;
                end
            end
            if (done_valid) begin
                done_cnt++;
                got_status = int'(done_status);
            end
        end
    end

    // mode: 0 bitmap request, 1 single trigger, 2 both at once; intrude: extra commands while busy
    task automatic run_case(input string req, input logic [7:0] bm, input int mode,
                            input logic [7:0] pre, input int ack, input logic [7:0] nm,
                            input int ea, input bit sl, input bit intrude);
        int st;
        bit e;
        ack_after = ack; nack_mask = nm; err_at = ea; slow = sl;
        trig_r = 8'h15; s1_r = 8'h00; s2_r = pre; last_rd = 8'h00;
        armed = 0; pcount = 0; txn_idx = 0; done_cnt = 0; got_status = -1;
        prev_poll_ok = 0; waited = 0;
        if (mode == 1) begin
            expq.delete();
            gen_idx = 0;
            g_rmw(A_TR, 8'h80, 8'h80, e);
            st = e ? 4 : 0;
        end else begin
            build_expect(bm, pre, st);
        end
        @(negedge clk);
        start_req = (mode != 1);
        single_req = (mode != 0);
        req_bitmap = bm;
        @(negedge clk);
        start_req = 1'b0;
        single_req = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            start_req = 1'b1; single_req = 1'b1; req_bitmap = 8'h40;
            @(negedge clk);
            start_req = 1'b0; single_req = 1'b0;
        end
        for (int n = 0; n < 1000 && done_cnt == 0; n++) @(posedge clk);
        repeat (12) @(posedge clk);
        chk(got_status == st, req, "result code", got_status, st);
        chk(expq.size() == 0, req, "accesses left unissued", expq.size(), 0);
        chk(done_cnt == 1, "R14", "completion pulses", done_cnt, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy, "R12", "busy after reset", int'(busy), 0);
        chk(!done_valid, "R14", "done after reset", int'(done_valid), 0);
        chk(!bus_req, "R12", "bus request after reset", int'(bus_req), 0);

        run_case("R2", 8'h00, 0, 8'h00, 1, 8'h00, -1, 0, 0);      // empty bitmap
        run_case("R6", 8'h01, 0, 8'h00, 1, 8'h00, -1, 0, 0);      // one bit, R9 clean-up
        run_case("R4", 8'hA5, 0, 8'h00, 2, 8'h00, -1, 1, 0);      // several bits, wait states (R13)
        run_case("R3", 8'h80, 0, 8'hFF, 1, 8'h00, -1, 0, 0);      // stale error cleared
        run_case("R4", 8'h41, 0, 8'h40, 1, 8'h00, -1, 0, 0);      // stale ack bit cleared first
        run_case("R7", 8'h06, 0, 8'h00, 1, 8'h04, -1, 0, 0);      // NACK on bit 2
        run_case("R8", 8'h10, 0, 8'h00, 0, 8'h00, -1, 0, 0);      // no answer: timeout
        run_case("R10", 8'h03, 0, 8'h00, 1, 8'h00, 5, 0, 0);      // error on trigger read
        run_case("R10", 8'h01, 0, 8'h00, 1, 8'h00, 0, 0, 0);      // error on initial status read
        run_case("R11", 8'h00, 1, 8'h00, 1, 8'h00, -1, 0, 0);     // trigger-only command
        run_case("R11", 8'h00, 1, 8'h00, 1, 8'h00, 1, 1, 0);      // trigger-only with write error
        run_case("R12", 8'h03, 0, 8'h00, 1, 8'h00, -1, 0, 1);     // commands while busy ignored
        run_case("R12", 8'h20, 2, 8'h00, 1, 8'h00, -1, 0, 0);     // both commands: bitmap wins

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule